// File: doc/BRIEF.md
# PCM/TDM Frame Timing Generator

This block keeps the frame timing of a serial audio port that runs in PCM or TDM mode. It advances a bit counter once per bit-clock enable. It reports the position of the current bit inside the frame, and it raises a strobe on the first bit of every frame. It also marks the bit on which the data path starts slot 0, and it drives a regenerated frame sync.

The frame sync can be made locally from the counter. It can also be taken from a sync input, where each detected sync edge re-aligns the counter. The sync is either one bit wide (short) or covers the first half of the frame (long). In long-sync mode the sync polarity can be inverted. The frame length comes from a power-of-two code in PCM mode, or from a free count of up to 512 bits in TDM mode.

All settings are static inputs. The block copies them into a working set only at a frame boundary, so a change never cuts a frame short.

Top module: `pcm_frame_timer`

## Requirements
- R1: In PCM mode (`cfg_tdm`=0) the frame is 2^(code+3) bit clocks long for `cfg_pcm_code` 0..5 (8, 16, 32, 64, 128, 256). Codes 6 and 7 give 256.
- R2: In TDM mode (`cfg_tdm`=1) the frame is `cfg_tdm_len_m1`+1 bit clocks long (2 to 512).
- R3: Each cycle with `bclk_en` high advances `bit_idx` by one. After index frame length−1 it wraps to 0. `frame_start` is high exactly while `bit_idx` is 0 and a frame is running.
- R4: With short sync (`cfg_long_sync`=0), `sync_out` is high only while `bit_idx` is 0.
- R5: With long sync (`cfg_long_sync`=1), the sync is active while `bit_idx` < frame length/2, with the half rounded down.
- R6: With `cfg_long_inv`=1 and long sync, `sync_out` is the complement of the R5 level, and a received sync is active low. With short sync, `cfg_long_inv` has no effect.
- R7: `data_start` is high while `bit_idx` equals 2, 1 or 0 for `cfg_delay` codes 0, 1 or 2. Code 3 acts as code 2.
- R8: With an external sync (`cfg_int_sync`=0), nothing runs until the first sync edge: `bit_idx`, `frame_start`, `sync_out` and `data_start` stay 0. An edge is a sample at the active level after a sample that was not, taken at `bclk_en`. The bit sampled with the edge becomes index 0. Between edges the counter keeps wrapping at the frame length, and a sync level held active adds no further edge.
- R9: `sync_err` goes high when a sync edge arrives while `bit_idx` is not frame length−1. It then stays high until reset. An edge that arrives on time leaves it low.
- R10: With an internal sync (`cfg_int_sync`=1), `sync_in` is ignored and `sync_err` never rises.
- R11: A change of any `cfg_*` input takes effect when the counter next moves to index 0. Before the first frame the inputs are used directly.
- R12: While `rst_n` is low, all outputs are 0 at once, including `sync_out` and `sync_err`. The block leaves reset on the second rising clock edge after `rst_n` goes high.
- R13: Outputs change only in the clock cycle after a cycle with `bclk_en` high, and they hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | One-cycle enable per bit clock |
| cfg_tdm | input | 1 | 0: PCM length code, 1: TDM length count |
| cfg_pcm_code | input | 3 | PCM frame length code |
| cfg_tdm_len_m1 | input | 9 | TDM frame length minus one |
| cfg_int_sync | input | 1 | 1: sync made locally, 0: sync taken from `sync_in` |
| cfg_long_sync | input | 1 | 0: short sync, 1: long (half-frame) sync |
| cfg_delay | input | 2 | Data delay code relative to the sync |
| cfg_long_inv | input | 1 | Invert sync polarity in long-sync mode |
| sync_in | input | 1 | External frame sync |
| bit_idx | output | 9 | Index of the current bit in the frame |
| frame_start | output | 1 | High on bit 0 of every frame |
| data_start | output | 1 | High on the first data bit of slot 0 |
| sync_out | output | 1 | Regenerated frame sync |
| sync_err | output | 1 | Sticky flag for a sync edge at the wrong count |

## Verification
Every result is due one clock after the cycle in which `bclk_en` was high, because the counter, the working configuration and the edge register all load on that edge and the outputs decode from them. The bench raises `bclk_en` on a falling edge for exactly one clock and reads the outputs on the following falling edge, half a period after the update. Reset is checked while `rst_n` is still low, because it takes hold at once. After release the bench waits three clocks before the first enable, which covers the two-stage release. The hold rule is checked by letting clocks pass with `bclk_en` low and comparing the outputs before and after.

// File: rtl/pft_pkg.sv
package pft_pkg;

  localparam int FRAME_MAX    = 512;
  localparam int IDX_W        = $clog2(FRAME_MAX);
  localparam int LEN_W        = IDX_W + 1;
  localparam int CODE_W       = 3;
  localparam int DLY_W        = 2;
  localparam int PCM_MIN_LOG2 = 3;
  localparam int PCM_TOP_CODE = 5;

  typedef struct packed {
    logic              tdm;
    logic [CODE_W-1:0] code;
    logic [IDX_W-1:0]  tdm_m1;
    logic              int_sync;
    logic              long_sync;
    logic              inv;
    logic [DLY_W-1:0]  dly;
  } frame_cfg_t;

  localparam frame_cfg_t CFG_RESET = '{
    tdm:       1'b0,
    code:      CODE_W'(2),
    tdm_m1:    IDX_W'(31),
    int_sync:  1'b0,
    long_sync: 1'b0,
    inv:       1'b0,
    dly:       DLY_W'(2)
  };

  // Frame length in bit clocks for a configuration.
  function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
    logic [CODE_W-1:0] k;
    if (c.tdm) begin
      return LEN_W'(c.tdm_m1) + LEN_W'(1);
    end
    k = (c.code > CODE_W'(PCM_TOP_CODE)) ? CODE_W'(PCM_TOP_CODE) : c.code;
    return LEN_W'(1) << (int'(k) + PCM_MIN_LOG2);
  endfunction

  // Bit index holding the first data bit for a delay code.
  function automatic logic [IDX_W-1:0] data_ofs(input logic [DLY_W-1:0] d);
    case (d)
      DLY_W'(0): return IDX_W'(2);
      DLY_W'(1): return IDX_W'(1);
      default:   return IDX_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/pft_rst_sync.sv
module pft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_s_n = stage_q[STAGES-1];

endmodule

// File: rtl/pft_cfg_shadow.sv
module pft_cfg_shadow
  import pft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  frame_cfg_t       cfg_in,
  output frame_cfg_t       act,
  output logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] half,
  output logic [IDX_W-1:0] dofs
);

  frame_cfg_t act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (cap_en) act_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= CFG_RESET;
    else        act_q <= act_d;
  end

  assign act  = act_q;
  assign len  = frame_len(act_q);
  assign half = len >> 1;
  assign dofs = data_ofs(act_q.dly);

endmodule

// File: rtl/pft_sync_detect.sv
module pft_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_en,
  input  logic sync_in,
  input  logic flip,
  output logic edge_hit
);

  logic lvl;
  logic prev_q, prev_d;

  assign lvl = sync_in ^ flip;

  always_comb begin
    prev_d = prev_q;
    if (bclk_en) prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign edge_hit = bclk_en & lvl & ~prev_q;

endmodule

// File: rtl/pft_counter.sv
module pft_counter
  import pft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic             ext,
  input  logic             edge_hit,
  input  logic [LEN_W-1:0] len,
  output logic [IDX_W-1:0] cnt,
  output logic             started,
  output logic             err,
  output logic             cap_en
);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             err_q, err_d;
  logic             at_last;
  logic             load0;

  assign at_last = run_q & ({1'b0, cnt_q} == (len - LEN_W'(1)));

  always_comb begin
    load0 = 1'b0;
    if (bclk_en) begin
      if (!run_q) load0 = ~ext | edge_hit;
      else        load0 = at_last | (ext & edge_hit);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    err_d = err_q;
    if (load0) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (bclk_en && run_q) begin
      cnt_d = cnt_q + IDX_W'(1);
    end
    if (bclk_en && run_q && ext && edge_hit && !at_last) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      err_q <= err_d;
    end
  end

  assign cnt     = cnt_q;
  assign started = run_q;
  assign err     = err_q;
  assign cap_en  = ~run_q | load0;

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pft_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              cfg_tdm,
  input  logic [CODE_W-1:0] cfg_pcm_code,
  input  logic [IDX_W-1:0]  cfg_tdm_len_m1,
  input  logic              cfg_int_sync,
  input  logic              cfg_long_sync,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cfg_long_inv,
  input  logic              sync_in,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              frame_start,
  output logic              data_start,
  output logic              sync_out,
  output logic              sync_err
);

  logic             rst_s_n;
  frame_cfg_t       cfg_in;
  frame_cfg_t       act;
  logic [LEN_W-1:0] act_len;
  logic [LEN_W-1:0] act_half;
  logic [IDX_W-1:0] act_dofs;
  logic             act_ext;
  logic             act_long;
  logic             flip;
  logic             edge_hit;
  logic [IDX_W-1:0] cnt;
  logic             started;
  logic             cap_en;
  logic             err;
  logic             lvl;

  pft_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  always_comb begin
    cfg_in.tdm       = cfg_tdm;
    cfg_in.code      = cfg_pcm_code;
    cfg_in.tdm_m1    = cfg_tdm_len_m1;
    cfg_in.int_sync  = cfg_int_sync;
    cfg_in.long_sync = cfg_long_sync;
    cfg_in.inv       = cfg_long_inv;
    cfg_in.dly       = cfg_delay;
  end

  pft_cfg_shadow u_cfg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .cap_en (cap_en),
    .cfg_in (cfg_in),
    .act    (act),
    .len    (act_len),
    .half   (act_half),
    .dofs   (act_dofs)
  );

  assign act_ext  = ~act.int_sync;
  assign act_long = act.long_sync;
  assign flip     = act.long_sync & act.inv;

  pft_sync_detect u_det (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .bclk_en  (bclk_en),
    .sync_in  (sync_in),
    .flip     (flip),
    .edge_hit (edge_hit)
  );

  pft_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .bclk_en  (bclk_en),
    .ext      (act_ext),
    .edge_hit (edge_hit),
    .len      (act_len),
    .cnt      (cnt),
    .started  (started),
    .err      (err),
    .cap_en   (cap_en)
  );

  always_comb begin
    if (act_long) lvl = ({1'b0, cnt} < act_half);
    else          lvl = (cnt == '0);
  end

  assign bit_idx     = cnt;
  assign frame_start = started & (cnt == '0);
  assign data_start  = started & (cnt == act_dofs);
  assign sync_out    = started & (lvl ^ flip);
  assign sync_err    = err;

endmodule

// File: rtl/pcm_frame_timer_chk.sv
module pft_checker
  import pft_pkg::*;
(
  input logic             clk,
  input logic             rst_s_n,
  input logic             bclk_en,
  input logic [IDX_W-1:0] bit_idx,
  input logic             frame_start,
  input logic             data_start,
  input logic             sync_out,
  input logic             sync_err,
  input logic [LEN_W-1:0] frame_len,
  input logic             act_ext,
  input logic             act_long,
  input logic             started
);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bclk_en && started && !act_ext && ({1'b0, bit_idx} != frame_len - LEN_W'(1)))
      |=> (bit_idx == $past(bit_idx) + IDX_W'(1)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bclk_en && started && ({1'b0, bit_idx} == frame_len - LEN_W'(1)))
      |=> (bit_idx == '0) && frame_start);

  assert_short_pulse_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (started && !act_long) |-> (sync_out == frame_start));

  assert_idle_before_run_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !started |-> (!frame_start && !sync_out && !data_start));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    sync_err |=> sync_err);

  assert_err_ext_only_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sync_err) |-> $past(act_ext));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bclk_en |=> ($stable(bit_idx) && $stable(sync_out) && $stable(data_start)));

endmodule

bind pcm_frame_timer pft_checker u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .bclk_en     (bclk_en),
  .bit_idx     (bit_idx),
  .frame_start (frame_start),
  .data_start  (data_start),
  .sync_out    (sync_out),
  .sync_err    (sync_err),
  .frame_len   (act_len),
  .act_ext     (act_ext),
  .act_long    (act_long),
  .started     (started)
);

// File: tb/pcm_frame_timer_test.sv
`timescale 1ns/1ps
module pcm_frame_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_en = 1'b0;
  logic       cfg_tdm = 1'b0;
  logic [2:0] cfg_pcm_code = 3'd2;
  logic [8:0] cfg_tdm_len_m1 = 9'd31;
  logic       cfg_int_sync = 1'b1;
  logic       cfg_long_sync = 1'b0;
  logic [1:0] cfg_delay = 2'd2;
  logic       cfg_long_inv = 1'b0;
  logic       sync_in = 1'b0;
  logic [8:0] bit_idx;
  logic       frame_start, data_start, sync_out, sync_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
    .cfg_tdm(cfg_tdm), .cfg_pcm_code(cfg_pcm_code), .cfg_tdm_len_m1(cfg_tdm_len_m1),
    .cfg_int_sync(cfg_int_sync), .cfg_long_sync(cfg_long_sync), .cfg_delay(cfg_delay),
    .cfg_long_inv(cfg_long_inv), .sync_in(sync_in),
    .bit_idx(bit_idx), .frame_start(frame_start), .data_start(data_start),
    .sync_out(sync_out), .sync_err(sync_err)
  );

  // Vector: {tdm, pcm_code[2:0], tdm_len_m1[8:0], long, inv, delay[1:0]}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 3'd2, 9'd0,   1'b0, 1'b0, 2'd2},
    {1'b0, 3'd0, 9'd0,   1'b1, 1'b1, 2'd0},
    {1'b0, 3'd1, 9'd0,   1'b0, 1'b1, 2'd1},
    {1'b1, 3'd0, 9'd11,  1'b1, 1'b0, 2'd2},
    {1'b0, 3'd5, 9'd0,   1'b1, 1'b0, 2'd1},
    {1'b1, 3'd0, 9'd511, 1'b0, 1'b0, 2'd0},
    {1'b0, 3'd3, 9'd0,   1'b1, 1'b1, 2'd3},
    {1'b0, 3'd4, 9'd0,   1'b0, 1'b0, 2'd2},
    {1'b0, 3'd7, 9'd0,   1'b1, 1'b0, 2'd1},
    {1'b1, 3'd0, 9'd4,   1'b1, 1'b1, 2'd1}
  };

  // Reference model state (internal sync only)
  bit       m_run;
  int       m_cnt, m_len, m_dofs;
  bit       m_long, m_inv;

  function automatic int len_of(bit tdm, int code, int m1);
    if (tdm) return m1 + 1;
    if (code > 5) code = 5;
    return 1 << (code + 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bclk_en = 1'b1;
    @(negedge clk) bclk_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R12 reset bit_idx", int'(bit_idx), 0);
    chk("R12 reset flags", int'({frame_start, data_start, sync_out, sync_err}), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_run = 0;
  endtask

  task automatic model_step();
    if (!m_run || m_cnt == m_len - 1) begin
      m_cnt  = 0;
      m_run  = 1;
      m_len  = len_of(cfg_tdm, int'(cfg_pcm_code), int'(cfg_tdm_len_m1));
      m_long = cfg_long_sync;
      m_inv  = cfg_long_inv;
      m_dofs = (cfg_delay == 2'd0) ? 2 : (cfg_delay == 2'd1) ? 1 : 0;
    end else begin
      m_cnt++;
    end
  endtask

  function automatic int model_out();
    bit fs, so, ds, lv;
    fs = (m_cnt == 0);
    lv = m_long ? (m_cnt < m_len / 2) : (m_cnt == 0);
    so = lv ^ (m_long & m_inv);
    ds = (m_cnt == m_dofs);
    return (m_cnt << 3) | (int'(fs) << 2) | (int'(so) << 1) | int'(ds);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hold_idx;
    int n;
    m_run = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // Table walk: internal sync, sync_in toggled to show it is ignored.
    cfg_int_sync = 1'b1;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      int ticks;
      cfg_tdm        = VEC[k][16];
      cfg_pcm_code   = VEC[k][15:13];
      cfg_tdm_len_m1 = VEC[k][12:4];
      cfg_long_sync  = VEC[k][3];
      cfg_long_inv   = VEC[k][2];
      cfg_delay      = VEC[k][1:0];
      ticks = (m_run ? m_len : 0) +
              2 * len_of(VEC[k][16], int'(VEC[k][15:13]), int'(VEC[k][12:4]));
      for (int t = 0; t < ticks; t++) begin
        sync_in = n[1];
        n++;
        tick();
        model_step();
        // R1 R2 R3 R4 R5 R6 R7 R11: index, frame strobe, sync, data strobe
        chk($sformatf("R1 R2 R3 R4 R5 R6 R7 R11 vec%0d bit%0d", k, t),
            int'({bit_idx, frame_start, sync_out, data_start}), model_out());
      end
    end
    chk("R10 internal sync ignores sync_in, no error", int'(sync_err), 0);

    // R13: outputs hold while bclk_en stays low
    hold_idx = int'(bit_idx);
    repeat (3) @(negedge clk);
    chk("R13 hold without enable", int'(bit_idx), hold_idx);

    // External short sync, 16-bit frame
    cfg_int_sync = 1'b0; cfg_tdm = 1'b0; cfg_pcm_code = 3'd1;
    cfg_long_sync = 1'b0; cfg_long_inv = 1'b0; cfg_delay = 2'd2;
    sync_in = 1'b0;
    do_reset();
    repeat (3) tick();
    chk("R8 idle before first sync idx", int'(bit_idx), 0);
    chk("R8 idle before first sync strobes", int'({frame_start, sync_out, data_start}), 0);
    sync_in = 1'b1; tick();
    chk("R8 first edge aligns frame", int'({bit_idx, frame_start, sync_out}), 3);
    sync_in = 1'b0;
    repeat (15) tick();
    chk("R8 free count to last bit", int'(bit_idx), 15);
    sync_in = 1'b1; tick();
    chk("R9 on-time edge idx", int'(bit_idx), 0);
    chk("R9 on-time edge no error", int'(sync_err), 0);
    sync_in = 1'b0;
    repeat (5) tick();
    sync_in = 1'b1; tick();
    chk("R8 early edge realigns", int'(bit_idx), 0);
    chk("R9 early edge sets error", int'(sync_err), 1);
    tick();
    chk("R8 held level gives no new edge", int'(bit_idx), 1);
    sync_in = 1'b0;
    repeat (14) tick();
    tick();
    chk("R8 flywheel wrap without sync", int'({bit_idx, frame_start}), 1);
    chk("R9 error stays set", int'(sync_err), 1);

    // External long sync, inverted, 8-bit frame: idle high, active low
    cfg_pcm_code = 3'd0; cfg_long_sync = 1'b1; cfg_long_inv = 1'b1;
    sync_in = 1'b1;
    do_reset();
    chk("R12 error cleared by reset", int'(sync_err), 0);
    repeat (2) tick();
    chk("R6 high level is not an edge when inverted", int'(frame_start), 0);
    sync_in = 1'b0; tick();
    chk("R6 R8 low edge aligns, sync driven low", int'({bit_idx, frame_start, sync_out}), 2);
    repeat (4) tick();
    chk("R5 R6 second half inactive high", int'({bit_idx, sync_out}), 9);
    chk("R9 no error on first edge", int'(sync_err), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule